// File: doc/BRIEF.md
# Dual-Issue In-Order Floating-Point Issue Scoreboard

This block sits between an instruction queue and two floating-point execution units: one adder and one multiplier. Each cycle the queue offers its two oldest decoded instructions. Each instruction carries a unit class (add or multiply), a destination register and two source registers. The block decides how many of the two may start, strictly in program order, and tells the queue which slots it took.

A per-register busy table tracks every destination that has an instruction in flight. An instruction waits while any register it names is busy. An issued instruction sets its destination busy. When the completion tag for that register comes back from the unit, the bit clears.

Both units are modelled as fixed-latency pipelines that return the destination register as their completion tag. Each unit also has an issue-interval controller with two named states:

- `U_READY`: the unit accepts an instruction.
- `U_HOLD`: the unit refuses new work.

The transitions are:

- *accept-with-interval*: `U_READY` goes to `U_HOLD` when the unit accepts an instruction and its interval is above one.
- *interval-expired*: `U_HOLD` goes back to `U_READY` when the hold counter reaches one.

With an interval of one, the unit never leaves `U_READY` and accepts one instruction every cycle.

Top module: `dual_issue_sb`

## Requirements
- R1: After reset, no register is busy, both units report ready, no completion is signalled, and the issue count is 0 while no slot is valid.
- R2: An add taken in cycle c raises `add_done` during cycle c+ADD_LAT, with `add_tag` equal to its destination.
- R3: A multiply taken in cycle c raises `mul_done` during cycle c+MUL_LAT, with `mul_tag` equal to its destination.
- R4: Slot 0 (the oldest, bit 0 of `in_vld` and `take`) is taken exactly when all of the following hold: it is valid, none of its destination or source registers is busy, and the unit of its class is ready. The class encoding is 0 = add and 1 = multiply.
- R5: Slot 1 is taken exactly when all of the following hold: slot 0 is taken, slot 1 is valid, its registers are not busy, its unit is ready, its class differs from slot 0's class, its sources differ from slot 0's destination, and its destination differs from slot 0's destination.
- R6: A taken instruction's destination reads busy from the next cycle through its completion cycle, and reads free from the cycle after completion.
- R7: A unit with issue interval II>1 that accepts in cycle c shows busy in `unit_busy` (bit 0 = adder, bit 1 = multiplier) and takes nothing during cycles c+1 to c+II-1.
- R8: `iss_cnt` equals the number of set bits of `take`. Slot 1 is never taken without slot 0.
- R9: When slot 1 writes a register that slot 0 only reads, the pair is not held back for that reason.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 2 | Slot valid bits, bit 0 = oldest |
| in_op0 | input | 1 | Slot 0 class, 0 = add, 1 = multiply |
| in_dst0 | input | RW | Slot 0 destination register |
| in_sa0 | input | RW | Slot 0 first source register |
| in_sb0 | input | RW | Slot 0 second source register |
| in_op1 | input | 1 | Slot 1 class |
| in_dst1 | input | RW | Slot 1 destination register |
| in_sa1 | input | RW | Slot 1 first source register |
| in_sb1 | input | RW | Slot 1 second source register |
| take | output | 2 | Slots issued this cycle (ready to the queue) |
| iss_cnt | output | 2 | Number of instructions issued this cycle |
| reg_busy | output | NREG | Busy bit per register |
| unit_busy | output | 2 | Unit not accepting, bit 0 = adder, bit 1 = multiplier |
| add_done | output | 1 | Adder completion valid |
| add_tag | output | RW | Adder completion register |
| mul_done | output | 1 | Multiplier completion valid |
| mul_tag | output | RW | Multiplier completion register |

## Verification
The bench builds the block with eight registers, adder latency 2, multiplier latency 5, adder interval 1 and multiplier interval 2. The small register file makes source, destination and same-slot conflicts frequent under random programs. The multiplier interval of two brings the `U_HOLD` state and its refusals into every multiply burst. The latency gap between the units keeps multiplies outstanding while several adds complete, which exercises clears and sets of the busy table in the same cycle on different registers.

// File: rtl/dis_pkg.sv
package dis_pkg;
    typedef enum logic {
        FU_ADD = 1'b0,
        FU_MUL = 1'b1
    } fu_e;

    typedef enum logic {
        U_READY = 1'b0,
        U_HOLD  = 1'b1
    } ustate_e;
endpackage

// File: rtl/dis_fu_pipe.sv
module dis_fu_pipe #(
    parameter int LAT = 2,
    parameter int II  = 1,
    parameter int RW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [RW-1:0] in_tag,
    output logic          ready,
    output logic          done,
    output logic [RW-1:0] done_tag
);
    import dis_pkg::*;

    localparam int HOLDN = (II > 1) ? II - 1 : 1;
    localparam int CW    = $clog2(HOLDN + 1);

    logic [LAT-1:0] vld_q;
    logic [RW-1:0]  tag_q [LAT];
    ustate_e        state, nstate;
    logic [CW-1:0]  hcnt, ncnt;

    // fixed-latency pipeline carrying the completion tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= accept;
            for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        tag_q[0] <= in_tag;
        for (int i = 1; i < LAT; i++) tag_q[i] <= tag_q[i-1];
    end

    assign done     = vld_q[LAT-1];
    assign done_tag = tag_q[LAT-1];

    // issue-interval state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= U_READY;
            hcnt  <= '0;
        end else begin
            state <= nstate;
            hcnt  <= ncnt;
        end
    end

    always_comb begin
        nstate = state;
        ncnt   = hcnt;
        unique case (state)
            U_READY: begin
                if (accept && (II > 1)) begin
                    nstate = U_HOLD;
                    ncnt   = CW'(HOLDN);
                end
            end
            U_HOLD: begin
                if (hcnt == CW'(1)) nstate = U_READY;
                else                ncnt   = hcnt - 1'b1;
            end
        endcase
    end

    always_comb begin
        ready = (state == U_READY);
    end

    a_r7_hold_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == U_HOLD) |-> !accept);

    a_r7_hold_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (II > 1)) |=> !ready);
endmodule

// File: rtl/dis_busy_tbl.sv
module dis_busy_tbl #(
    parameter int NREG = 32,
    parameter int RW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set0_en,
    input  logic [RW-1:0]   set0_idx,
    input  logic            set1_en,
    input  logic [RW-1:0]   set1_idx,
    input  logic            clr0_en,
    input  logic [RW-1:0]   clr0_idx,
    input  logic            clr1_en,
    input  logic [RW-1:0]   clr1_idx,
    output logic [NREG-1:0] busy
);
    logic [NREG-1:0] set_vec, clr_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign set_vec[g] = (set0_en && set0_idx == RW'(g)) || (set1_en && set1_idx == RW'(g));
        assign clr_vec[g] = (clr0_en && clr0_idx == RW'(g)) || (clr1_en && clr1_idx == RW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          busy[g] <= 1'b0;
            else if (set_vec[g]) busy[g] <= 1'b1;
            else if (clr_vec[g]) busy[g] <= 1'b0;
        end
    end

    // R6: a register is never claimed and released in the same cycle
    a_r6_set_clr_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec & clr_vec) == '0);

    a_r6_clear_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec & ~busy) == '0);

    a_r6_set_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec & busy) == '0);

    a_r6_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((busy & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/dis_issue_sel.sv
module dis_issue_sel #(
    parameter int NREG = 32,
    parameter int RW   = 5
) (
    input  logic [NREG-1:0] busy,
    input  logic [1:0]      unit_rdy,
    input  logic [1:0]      vld,
    input  logic            op0,
    input  logic [RW-1:0]   d0,
    input  logic [RW-1:0]   a0,
    input  logic [RW-1:0]   b0,
    input  logic            op1,
    input  logic [RW-1:0]   d1,
    input  logic [RW-1:0]   a1,
    input  logic [RW-1:0]   b1,
    output logic [1:0]      take
);
    function automatic logic regs_free(input logic [NREG-1:0] bz,
                                       input logic [RW-1:0] d,
                                       input logic [RW-1:0] a,
                                       input logic [RW-1:0] b);
        return !(bz[d] || bz[a] || bz[b]);
    endfunction

    logic ok0, ok1, pair_ok;

    always_comb begin
        ok0     = vld[0] && regs_free(busy, d0, a0, b0) && unit_rdy[op0];
        pair_ok = (op1 != op0) && (d1 != d0) && (a1 != d0) && (b1 != d0);
        ok1     = ok0 && vld[1] && regs_free(busy, d1, a1, b1) && unit_rdy[op1] && pair_ok;
        take    = {ok1, ok0};
    end
endmodule

// File: rtl/dual_issue_sb.sv
module dual_issue_sb #(
    parameter int NREG    = 32,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 5,
    parameter int ADD_II  = 1,
    parameter int MUL_II  = 1,
    localparam int RW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      in_vld,
    input  logic            in_op0,
    input  logic [RW-1:0]   in_dst0,
    input  logic [RW-1:0]   in_sa0,
    input  logic [RW-1:0]   in_sb0,
    input  logic            in_op1,
    input  logic [RW-1:0]   in_dst1,
    input  logic [RW-1:0]   in_sa1,
    input  logic [RW-1:0]   in_sb1,
    output logic [1:0]      take,
    output logic [1:0]      iss_cnt,
    output logic [NREG-1:0] reg_busy,
    output logic [1:0]      unit_busy,
    output logic            add_done,
    output logic [RW-1:0]   add_tag,
    output logic            mul_done,
    output logic [RW-1:0]   mul_tag
);
    import dis_pkg::*;

    logic          add_rdy, mul_rdy;
    logic          add_go, mul_go;
    logic [RW-1:0] add_dst, mul_dst;
    logic          s0_add, s0_mul, s1_add, s1_mul;

    dis_issue_sel #(.NREG(NREG), .RW(RW)) u_sel (
        .busy(reg_busy), .unit_rdy({mul_rdy, add_rdy}), .vld(in_vld),
        .op0(in_op0), .d0(in_dst0), .a0(in_sa0), .b0(in_sb0),
        .op1(in_op1), .d1(in_dst1), .a1(in_sa1), .b1(in_sb1),
        .take(take)
    );

    always_comb begin
        s0_add  = take[0] && (fu_e'(in_op0) == FU_ADD);
        s0_mul  = take[0] && (fu_e'(in_op0) == FU_MUL);
        s1_add  = take[1] && (fu_e'(in_op1) == FU_ADD);
        s1_mul  = take[1] && (fu_e'(in_op1) == FU_MUL);
        add_go  = s0_add || s1_add;
        mul_go  = s0_mul || s1_mul;
        add_dst = s0_add ? in_dst0 : in_dst1;
        mul_dst = s0_mul ? in_dst0 : in_dst1;
        iss_cnt = 2'(take[0]) + 2'(take[1]);
        unit_busy = {!mul_rdy, !add_rdy};
    end

    dis_fu_pipe #(.LAT(ADD_LAT), .II(ADD_II), .RW(RW)) u_add (
        .clk(clk), .rst_n(rst_n), .accept(add_go), .in_tag(add_dst),
        .ready(add_rdy), .done(add_done), .done_tag(add_tag)
    );

    dis_fu_pipe #(.LAT(MUL_LAT), .II(MUL_II), .RW(RW)) u_mul (
        .clk(clk), .rst_n(rst_n), .accept(mul_go), .in_tag(mul_dst),
        .ready(mul_rdy), .done(mul_done), .done_tag(mul_tag)
    );

    dis_busy_tbl #(.NREG(NREG), .RW(RW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .set0_en(take[0]), .set0_idx(in_dst0),
        .set1_en(take[1]), .set1_idx(in_dst1),
        .clr0_en(add_done), .clr0_idx(add_tag),
        .clr1_en(mul_done), .clr1_idx(mul_tag),
        .busy(reg_busy)
    );

    a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        take[1] |-> take[0]);

    a_r4_free_regs: assert property (@(posedge clk) disable iff (!rst_n)
        take[0] |-> !(reg_busy[in_dst0] || reg_busy[in_sa0] || reg_busy[in_sb0]));

    a_r4_unit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        take[0] |-> !unit_busy[in_op0]);

    a_r5_mixed_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (&take) |-> (in_op0 != in_op1));

    a_r5_no_raw_waw: assert property (@(posedge clk) disable iff (!rst_n)
        take[1] |-> (in_sa1 != in_dst0 && in_sb1 != in_dst0 && in_dst1 != in_dst0));

    a_r6_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        take[0] |=> reg_busy[$past(in_dst0)]);
endmodule

// File: tb/dual_issue_sb_test.sv
module dual_issue_sb_test;
    localparam int NREG = 8, ADD_LAT = 2, MUL_LAT = 5, ADD_II = 1, MUL_II = 2;
    localparam int RW = $clog2(NREG);
    localparam int N = 700;

    logic clk = 0, rst_n = 0;
    logic [1:0] in_vld;
    logic in_op0, in_op1;
    logic [RW-1:0] in_dst0, in_sa0, in_sb0, in_dst1, in_sa1, in_sb1;
    logic [1:0] take, iss_cnt, unit_busy;
    logic [NREG-1:0] reg_busy;
    logic add_done, mul_done;
    logic [RW-1:0] add_tag, mul_tag;

    always #5 clk = ~clk;

    dual_issue_sb #(.NREG(NREG), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT),
                    .ADD_II(ADD_II), .MUL_II(MUL_II)) uut (.*);

    int total = 0, bad = 0;
    bit ended = 0;
    int p_op[N], p_d[N], p_a[N], p_b[N];
    int cnt[NREG];
    int uof[NREG];
    int hold[2];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit free3(input int d, input int a, input int b);
        return cnt[d] == 0 && cnt[a] == 0 && cnt[b] == 0;
    endfunction

    task automatic put(input int i, input int op, input int d, input int a, input int b);
        p_op[i] = op; p_d[i] = d; p_a[i] = a; p_b[i] = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int head, cyc, e0, e1, ebusy, eadd, eaddt, emul, emult;
        bit v0, v1;
        void'($urandom(32'd4242));
        // directed prefix: WAR pair, same-unit pair, RAW pair, chained example
        put(0, 0, 1, 3, 4); put(1, 1, 3, 0, 5);
        put(2, 0, 2, 0, 5); put(3, 0, 4, 0, 5);
        put(4, 1, 5, 4, 0);
        put(5, 0, 2, 0, 1); put(6, 1, 2, 2, 3);
        put(7, 0, 6, 2, 7); put(8, 0, 1, 1, 3);
        for (int i = 9; i < N; i++)
            put(i, $urandom_range(0, 1), $urandom_range(0, NREG - 1),
                $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1));
        for (int r = 0; r < NREG; r++) begin cnt[r] = 0; uof[r] = 0; end
        hold[0] = 0; hold[1] = 0;
        in_vld = 0; in_op0 = 0; in_op1 = 0;
        in_dst0 = 0; in_sa0 = 0; in_sb0 = 0; in_dst1 = 0; in_sa1 = 0; in_sb1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 busy", int'(reg_busy), 0);
        chk("R1 unit_busy", int'(unit_busy), 0);
        chk("R1 add_done", int'(add_done), 0);
        chk("R1 mul_done", int'(mul_done), 0);
        chk("R1 iss_cnt", int'(iss_cnt), 0);
        head = 0; cyc = 0;
        while (cyc < 20000) begin
            bit any;
            any = 0;
            for (int r = 0; r < NREG; r++) if (cnt[r] != 0) any = 1;
            if (head >= N && !any) break;
            @(negedge clk);
            v0 = (head < N) && (cyc < 4 || $urandom_range(0, 9) != 0);
            v1 = v0 && (head + 1 < N) && (cyc < 4 || $urandom_range(0, 7) != 0);
            in_vld = {v1, v0};
            if (head < N) begin
                in_op0 = p_op[head][0]; in_dst0 = RW'(p_d[head]);
                in_sa0 = RW'(p_a[head]); in_sb0 = RW'(p_b[head]);
            end
            if (head + 1 < N) begin
                in_op1 = p_op[head+1][0]; in_dst1 = RW'(p_d[head+1]);
                in_sa1 = RW'(p_a[head+1]); in_sb1 = RW'(p_b[head+1]);
            end
            #1;
            e0 = (v0 && free3(p_d[head], p_a[head], p_b[head]) && hold[p_op[head]] == 0) ? 1 : 0;
            e1 = 0;
            if (e0 == 1 && v1) begin
                int j;
                j = head + 1;
                if (free3(p_d[j], p_a[j], p_b[j]) && hold[p_op[j]] == 0 &&
                    p_op[j] != p_op[head] && p_d[j] != p_d[head] &&
                    p_a[j] != p_d[head] && p_b[j] != p_d[head]) e1 = 1;
            end
            ebusy = 0; eadd = 0; eaddt = 0; emul = 0; emult = 0;
            for (int r = 0; r < NREG; r++) begin
                if (cnt[r] != 0) ebusy |= (1 << r);
                if (cnt[r] == 1 && uof[r] == 0) begin eadd = 1; eaddt = r; end
                if (cnt[r] == 1 && uof[r] == 1) begin emul = 1; emult = r; end
            end
            chk("R4 slot0 take", int'(take[0]), e0);
            chk("R5 slot1 take", int'(take[1]), e1);
            chk("R8 iss_cnt", int'(iss_cnt), e0 + e1);
            chk("R6 busy", int'(reg_busy), ebusy);
            chk("R7 unit_busy", int'(unit_busy), ((hold[1] != 0) ? 2 : 0) | ((hold[0] != 0) ? 1 : 0));
            chk("R2 add_done", int'(add_done), eadd);
            if (eadd == 1) chk("R2 add_tag", int'(add_tag), eaddt);
            chk("R3 mul_done", int'(mul_done), emul);
            if (emul == 1) chk("R3 mul_tag", int'(mul_tag), emult);
            if (cyc == 0) chk("R9 WAR pair issues together", int'(take), 3);
            if (cyc == 1) chk("R5 two adds split", int'(take), 1);
            if (cyc == 1) chk("R7 mul held", int'(unit_busy[1]), 1);
            if (cyc == 2) chk("R5 RAW blocks slot1", int'(take), 1);
            @(posedge clk);
            for (int r = 0; r < NREG; r++) if (cnt[r] > 0) cnt[r]--;
            for (int u = 0; u < 2; u++) if (hold[u] > 0) hold[u]--;
            if (e0 == 1) begin
                cnt[p_d[head]] = (p_op[head] == 0) ? ADD_LAT : MUL_LAT;
                uof[p_d[head]] = p_op[head];
                hold[p_op[head]] = ((p_op[head] == 0) ? ADD_II : MUL_II) - 1;
            end
            if (e1 == 1) begin
                cnt[p_d[head+1]] = (p_op[head+1] == 0) ? ADD_LAT : MUL_LAT;
                uof[p_d[head+1]] = p_op[head+1];
                hold[p_op[head+1]] = ((p_op[head+1] == 0) ? ADD_II : MUL_II) - 1;
            end
            head += e0 + e1;
            cyc++;
        end
        @(negedge clk);
        in_vld = 0;
        #1;
        chk("R6 drained busy", int'(reg_busy), 0);
        chk("R8 idle count", int'(iss_cnt), 0);
        chk("R4 program consumed", head, N);
        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule